// File: doc/BRIEF.md
# Learned/Aged Queue and Write-Exception Interrupt Controller

This block merges four event sources of an address-lookup engine into one interrupt line. Two sources are lookup queues: one holds freshly learned entries and one holds entries that have expired. The block watches their occupancy levels. The other two sources are write-exception pulses. One comes from the synchronous lookup port and one from the host register port. Each pulse means a write was still in flight when the table had too little room for it. Every source keeps a flag bit that host software can read. Each source also has its own enable bit that gates it onto the interrupt line.

Software acknowledges a source by reading that source's flag. A queue source then stays quiet, even while entries keep arriving, until its queue has been seen empty and has filled again. This keeps a busy queue from raising an interrupt storm. The software routine drains the queue and then waits for the next time the queue goes from empty to non-empty. An exception flag is different: it holds until it is read, and any new exception sets it again straight away. The register decode and the queues themselves sit outside this block. The block receives one read strobe per flag.

Top module: `qevt_irq_top`

## Requirements
- R1: When reset is active (synchronous, active high), all four flag bits and the interrupt output are 0 after the next clock edge.
- R2: A queue source is armed out of reset. If an armed queue reports a non-zero level at a clock edge, its flag reads 1 after that edge. Flag bit 0 is the learned queue and bit 1 is the aged queue.
- R3: If a flag's read strobe is high in a cycle, the flag still shows its old value during that cycle. After the edge it reads 0, unless R7 applies. Read strobe bit n belongs to flag bit n.
- R4: After a queue flag is acknowledged while that queue is non-empty, the flag stays 0 for as long as the level stays non-zero. This holds even if the level rises.
- R5: Once a queue's level has been seen at zero at a clock edge, a later non-zero level sets its flag again.
- R6: A write-exception pulse sets its flag after the edge. The flag then stays 1 until it is read. Pulse bit 0 (synchronous port) sets flag bit 2, and pulse bit 1 (host port) sets flag bit 3.
- R7: If an exception pulse and that flag's read strobe arrive in the same cycle, the flag reads 1 after the edge.
- R8: Flags set whatever the enables are. Enable bit n allows only flag bit n to drive the interrupt.
- R9: The interrupt output is registered. It equals the OR of (flag AND enable) as it stood before the previous clock edge, so it follows the flags one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_en | input | 4 | Per-source interrupt enable, same bit order as flags |
| lrn_level | input | OCC_W | Occupancy of the learned-entry queue |
| age_level | input | OCC_W | Occupancy of the expired-entry queue |
| wex_pulse | input | 2 | Write-exception pulses: bit 0 synchronous port, bit 1 host port |
| flag_rd | input | 4 | Read strobes, one per flag; a strobe acknowledges its flag |
| flags | output | 4 | Readable flag bits: 0 learned, 1 aged, 2 sync exception, 3 host exception |
| irq | output | 1 | Registered interrupt line |

## Verification
Each source keeps its internal state in one or two bits: the armed and pending bits of a queue, or the sticky bit of an exception. A wrong value in any of them shows on the flags output one edge after the stimulus that should have set or cleared it. It shows on the interrupt line one edge later still. The hardest case to catch is a queue that re-arms wrongly. That error only shows when a queue is acknowledged while still non-empty, so the bench pushes the level higher after acknowledging and watches the flag stay low. It then empties and refills the queue and checks that the flag comes back. Every combination of enable mask and active-source pattern is covered. Any mis-gated or mis-ordered source therefore changes the interrupt value within two cycles.

// File: rtl/qevt_irq_pkg.sv
package qevt_irq_pkg;

    localparam int unsigned NUM_QUEUE = 2;
    localparam int unsigned NUM_WEX   = 2;
    localparam int unsigned NUM_SRC   = NUM_QUEUE + NUM_WEX;

    // state of one queue source
    typedef struct packed {
        logic armed;    // may fire on the next non-empty observation
        logic pend;     // flag visible to software
    } qtrk_t;

    localparam qtrk_t QTRK_RESET = '{armed: 1'b1, pend: 1'b0};

    function automatic logic any_live(input logic [NUM_SRC-1:0] f,
                                      input logic [NUM_SRC-1:0] en);
        return |(f & en);
    endfunction

endpackage

// File: rtl/qevt_queue_src.sv
module qevt_queue_src
    import qevt_irq_pkg::*;
#(
    parameter int unsigned OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] level,
    input  logic             rd_ack,
    output logic             flag
);

    qtrk_t st_q, st_d;
    logic  nonempty;

    assign nonempty = |level;

    always_comb begin
        st_d = st_q;
        // an observed empty queue re-arms; a read disarms it
        if (!nonempty)
            st_d.armed = 1'b1;
        else if (rd_ack)
            st_d.armed = 1'b0;
        // acknowledge wins over a new observation in the same cycle
        if (rd_ack)
            st_d.pend = 1'b0;
        else if (st_q.armed && nonempty)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= QTRK_RESET;
        else
            st_q <= st_d;
    end

    assign flag = st_q.pend;

    AST_Q_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !flag);  // R3
    AST_Q_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
        (!st_q.armed && !flag) |=> !flag);  // R4
    AST_Q_FIRES: assert property (@(posedge clk) disable iff (rst)
        (st_q.armed && nonempty && !rd_ack) |=> flag);  // R2

endmodule

// File: rtl/qevt_wex_src.sv
module qevt_wex_src (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  logic rd_ack,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= pulse | (flag_q & ~rd_ack);
    end

    assign flag = flag_q;

    AST_WEX_SET: assert property (@(posedge clk) disable iff (rst)
        pulse |=> flag);  // R7
    AST_WEX_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_ack) |=> flag);  // R6
    AST_WEX_DROP: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !pulse) |=> !flag);  // R3

endmodule

// File: rtl/qevt_irq_merge.sv
module qevt_irq_merge
    import qevt_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] en,
    output logic               irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= any_live(flags, en);
    end

    assign irq = irq_q;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((flags & en) == '0) |=> !irq);  // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(flags & en) != '0));  // R8

endmodule

// File: rtl/qevt_irq_top.sv
module qevt_irq_top
    import qevt_irq_pkg::*;
#(
    parameter int unsigned OCC_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [OCC_W-1:0]   lrn_level,
    input  logic [OCC_W-1:0]   age_level,
    input  logic [NUM_WEX-1:0] wex_pulse,
    input  logic [NUM_SRC-1:0] flag_rd,
    output logic [NUM_SRC-1:0] flags,
    output logic               irq
);

    logic [OCC_W-1:0] q_level [NUM_QUEUE];

    assign q_level[0] = lrn_level;
    assign q_level[1] = age_level;

    for (genvar g = 0; g < NUM_QUEUE; g++) begin : g_queue
        qevt_queue_src #(.OCC_W(OCC_W)) i_qsrc (
            .clk    (clk),
            .rst    (rst),
            .level  (q_level[g]),
            .rd_ack (flag_rd[g]),
            .flag   (flags[g])
        );
    end

    for (genvar w = 0; w < NUM_WEX; w++) begin : g_wex
        qevt_wex_src i_wsrc (
            .clk    (clk),
            .rst    (rst),
            .pulse  (wex_pulse[w]),
            .rd_ack (flag_rd[NUM_QUEUE+w]),
            .flag   (flags[NUM_QUEUE+w])
        );
    end

    qevt_irq_merge i_merge (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .en    (src_en),
        .irq   (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && !irq));  // R1

endmodule

// File: tb/test_qevt_irq_top.sv
module test_qevt_irq_top;

    localparam int CLK_PERIOD = 10;
    localparam int OCC_W      = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       src_en = '0;
    logic [OCC_W-1:0] lrn_level = '0;
    logic [OCC_W-1:0] age_level = '0;
    logic [1:0]       wex_pulse = '0;
    logic [3:0]       flag_rd = '0;
    logic [3:0]       flags;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    qevt_irq_top #(.OCC_W(OCC_W)) i_qevt_irq_top (
        .clk       (clk),
        .rst       (rst),
        .src_en    (src_en),
        .lrn_level (lrn_level),
        .age_level (age_level),
        .wex_pulse (wex_pulse),
        .flag_rd   (flag_rd),
        .flags     (flags),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic run_combo(input logic [3:0] en, input logic [3:0] p);
        logic expi;
        expi = |(p & en);
        rst = 1'b1; flag_rd = '0; wex_pulse = '0; lrn_level = '0; age_level = '0;
        src_en = en;
        repeat (2) @(negedge clk);
        chk({irq, flags}, 5'b0, "R1 reset state");
        rst = 1'b0;
        lrn_level = p[0] ? 4'd3 : 4'd0;
        age_level = p[1] ? 4'd2 : 4'd0;
        wex_pulse = p[3:2];
        @(negedge clk);
        wex_pulse = '0;
        chk(flags, p, "R2/R6 flags set");
        chk({3'b0, irq}, 4'b0, "R9 irq one cycle late");
        @(negedge clk);
        chk(flags, p, "R6 flags held");
        chk({3'b0, irq}, {3'b0, expi}, "R8 enable gating");
        flag_rd = 4'hF;
        #1;
        chk(flags, p, "R3 old value visible during read");
        @(negedge clk);
        flag_rd = '0;
        chk(flags, 4'b0, "R3 read clears");
        chk({3'b0, irq}, {3'b0, expi}, "R9 irq lags clear");
        lrn_level = p[0] ? 4'd9 : 4'd0;
        age_level = p[1] ? 4'd6 : 4'd0;
        @(negedge clk);
        chk({3'b0, irq}, 4'b0, "R9 irq drops");
        @(negedge clk);
        chk(flags, 4'b0, "R4 no refire while non-empty");
        lrn_level = '0; age_level = '0;
        @(negedge clk);
        lrn_level = 4'd1; age_level = 4'd1;
        @(negedge clk);
        chk({2'b0, flags[1:0]}, 4'b0011, "R5 rearm after empty");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        for (int en = 0; en < 16; en++) begin
            for (int p = 0; p < 16; p++) begin
                run_combo(4'(en), 4'(p));
            end
        end

        // R7: new exception in the same cycle as its read
        rst = 1'b1; flag_rd = '0; wex_pulse = '0; lrn_level = '0; age_level = '0;
        src_en = 4'hF;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int w = 0; w < 2; w++) begin
            wex_pulse = 2'(1 << w);
            @(negedge clk);
            wex_pulse = '0;
            repeat (3) @(negedge clk);
            chk({3'b0, flags[2+w]}, 4'b1, "R6 sticky after idle");
            wex_pulse = 2'(1 << w);
            flag_rd = 4'(1 << (2 + w));
            @(negedge clk);
            wex_pulse = '0; flag_rd = '0;
            chk({3'b0, flags[2+w]}, 4'b1, "R7 pulse beats read");
            flag_rd = 4'(1 << (2 + w));
            @(negedge clk);
            flag_rd = '0;
            chk({3'b0, flags[2+w]}, 4'b0, "R3 exception read clears");
        end

        done = 1;
        summary();
    end

endmodule